// File: doc/BRIEF.md
# Display RAM Address Generator

This block sits between a command and data byte stream and a monochrome display memory of 65 rows by 96 columns. The memory is laid out as 96 columns by 9 banks; each bank holds eight rows per column byte, and the last bank carries only one real row. The block keeps a column pointer and a bank pointer that commands can load, plus a small configuration word.

For every accepted data byte it issues one memory write. The write address comes from the current pointers after optional column and bank mirroring, and the byte is optionally bit-reversed. The pointers then step in either horizontal or vertical order and wrap around to address 0 after the last location.

Commands and data may arrive in the same cycle. The data byte always uses the pointers and configuration that were in force before that cycle's command. A pointer load overrides the step only on the axis it loads.

Top module: `dram_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the column and bank pointers to 0, selects horizontal stepping, clears both mirror flags and the bit-order flag, and holds `wr_en` low.
- R2: A byte on `data_valid` produces exactly one cycle of `wr_en` on the following clock cycle, carrying that byte's address and data; a cycle without `data_valid` gives `wr_en` low on the next cycle.
- R3: Without mirroring, the write address is bank × 96 + column, and it always lies in 0 to 863.
- R4: In horizontal mode (config bit 0 = 0), each byte increments the column; from column 95 the column returns to 0 and the bank increments.
- R5: In vertical mode (config bit 0 = 1), each byte increments the bank; from bank 8 the bank returns to 0 and the column increments.
- R6: A byte written at column 95, bank 8 returns both pointers to 0 in either mode.
- R7: Command encoding on `cmd_op`: 0 loads the column from `cmd_arg`, 1 loads the bank from `cmd_arg`, 2 loads the configuration from `cmd_arg[3:0]`, and 3 does nothing.
- R8: A column load with a value above 95 or a bank load with a value above 8 is ignored, and both pointers keep their values.
- R9: With column mirroring (config bit 1 = 1), the physical column is 95 − column.
- R10: With bank mirroring (config bit 2 = 1), the physical bank is 8 − bank.
- R11: With the bit-order flag (config bit 3 = 1), the stored byte is the input byte bit-reversed (bit 0 goes to bit 7); with the flag clear, the byte is stored unchanged.
- R12: When a command and a data byte arrive in the same cycle, the write uses the configuration and pointers from before the command, and the step uses the old mode. A column or bank load then replaces the stepped value on its own axis only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code (see R7) |
| cmd_arg | input | 8 | Command argument |
| data_valid | input | 1 | Display byte present this cycle |
| data_byte | input | 8 | Display byte |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 10 | Memory write address |
| wr_data | output | 8 | Memory write data |
| ptr_x | output | 7 | Current column pointer |
| ptr_y | output | 4 | Current bank pointer |

## Verification
A pointer or configuration command can coincide with a data byte. The bench provokes this by driving both strobes in one cycle: a column load with a vertical-mode byte, a bank load with a horizontal-mode byte at column 95 where the column wraps, and a configuration change with a mirrored, reversed byte. Each case is judged by checking that the write carries the address and byte computed from the old state. The following pointers must show the loaded axis taking the command value and the other axis taking the stepped value.

// File: rtl/dram_pkg.sv
package dram_pkg;

    localparam int unsigned DEF_COLS  = 96;
    localparam int unsigned DEF_BANKS = 9;
    localparam int unsigned DEF_DW    = 8;

    typedef enum logic [1:0] {
        OP_SET_COL  = 2'd0,
        OP_SET_BANK = 2'd1,
        OP_SET_CFG  = 2'd2,
        OP_NOP      = 2'd3
    } cmd_op_e;

    // bit 0 vertical, bit 1 column mirror, bit 2 bank mirror, bit 3 bit order
    typedef struct packed {
        logic rev_bits;
        logic mir_bank;
        logic mir_col;
        logic vertical;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{rev_bits: 1'b0, mir_bank: 1'b0, mir_col: 1'b0, vertical: 1'b0};

endpackage

// File: rtl/dram_cfg.sv
module dram_cfg
    import dram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/dram_ptr.sv
module dram_ptr #(
    parameter int unsigned NCOL  = 96,
    parameter int unsigned NBANK = 9,
    parameter int unsigned ARGW  = 8,
    localparam int unsigned XW = $clog2(NCOL),
    localparam int unsigned YW = $clog2(NBANK)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic            vertical,
    input  logic            ld_col,
    input  logic            ld_bank,
    input  logic [ARGW-1:0] arg,
    output logic [XW-1:0]   x_q,
    output logic [YW-1:0]   y_q
);

    localparam logic [XW-1:0] X_LAST = XW'(NCOL - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(NBANK - 1);

    logic [XW-1:0] x_step;
    logic [YW-1:0] y_step;
    logic          col_ok;
    logic          bank_ok;

    assign col_ok  = ({24'd0, arg} < 32'(NCOL));
    assign bank_ok = ({24'd0, arg} < 32'(NBANK));

    always_comb begin
        x_step = x_q;
        y_step = y_q;
        if (step) begin
            if (!vertical) begin
                if (x_q == X_LAST) begin
                    x_step = '0;
                    y_step = (y_q == Y_LAST) ? '0 : y_q + 1'b1;
                end else begin
                    x_step = x_q + 1'b1;
                end
            end else begin
                if (y_q == Y_LAST) begin
                    y_step = '0;
                    x_step = (x_q == X_LAST) ? '0 : x_q + 1'b1;
                end else begin
                    y_step = y_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= (ld_col && col_ok) ? XW'(arg) : x_step;
            y_q <= (ld_bank && bank_ok) ? YW'(arg) : y_step;
        end
    end

endmodule

// File: rtl/dram_map.sv
module dram_map
    import dram_pkg::*;
#(
    parameter int unsigned NCOL  = 96,
    parameter int unsigned NBANK = 9,
    parameter int unsigned DW    = 8,
    localparam int unsigned XW = $clog2(NCOL),
    localparam int unsigned YW = $clog2(NBANK),
    localparam int unsigned AW = $clog2(NCOL * NBANK)
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  cfg_t          cfg,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout
);

    logic [XW-1:0] phys_col;
    logic [YW-1:0] phys_bank;
    logic [DW-1:0] din_rev;

    assign phys_col  = cfg.mir_col  ? (XW'(NCOL - 1)  - x) : x;
    assign phys_bank = cfg.mir_bank ? (YW'(NBANK - 1) - y) : y;
    assign addr      = AW'(phys_bank) * AW'(NCOL) + AW'(phys_col);

    for (genvar b = 0; b < DW; b++) begin : g_rev
        assign din_rev[b] = din[DW-1-b];
    end

    assign dout = cfg.rev_bits ? din_rev : din;

endmodule

// File: rtl/dram_addr_gen.sv
module dram_addr_gen
    import dram_pkg::*;
#(
    parameter int unsigned NCOL  = DEF_COLS,
    parameter int unsigned NBANK = DEF_BANKS,
    parameter int unsigned DW    = DEF_DW,
    localparam int unsigned XW = $clog2(NCOL),
    localparam int unsigned YW = $clog2(NBANK),
    localparam int unsigned AW = $clog2(NCOL * NBANK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [7:0]    cmd_arg,
    input  logic          data_valid,
    input  logic [DW-1:0] data_byte,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [XW-1:0] ptr_x,
    output logic [YW-1:0] ptr_y
);

    cmd_op_e       op;
    cfg_t          cfg_q;
    logic          ld_col;
    logic          ld_bank;
    logic          ld_cfg;
    logic [AW-1:0] map_addr;
    logic [DW-1:0] map_data;
    logic          mode_vertical;

    assign op      = cmd_op_e'(cmd_op);
    assign ld_col  = cmd_valid && (op == OP_SET_COL);
    assign ld_bank = cmd_valid && (op == OP_SET_BANK);
    assign ld_cfg  = cmd_valid && (op == OP_SET_CFG);
    assign mode_vertical = cfg_q.vertical;

    dram_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (ld_cfg),
        .cfg_in (cfg_t'(cmd_arg[3:0])),
        .cfg_q  (cfg_q)
    );

    dram_ptr #(.NCOL(NCOL), .NBANK(NBANK), .ARGW(8)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .step     (data_valid),
        .vertical (cfg_q.vertical),
        .ld_col   (ld_col),
        .ld_bank  (ld_bank),
        .arg      (cmd_arg),
        .x_q      (ptr_x),
        .y_q      (ptr_y)
    );

    dram_map #(.NCOL(NCOL), .NBANK(NBANK), .DW(DW)) u_map (
        .x    (ptr_x),
        .y    (ptr_y),
        .cfg  (cfg_q),
        .din  (data_byte),
        .addr (map_addr),
        .dout (map_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= data_valid;
            if (data_valid) begin
                wr_addr <= map_addr;
                wr_data <= map_data;
            end
        end
    end

endmodule

// File: rtl/dram_addr_gen_chk.sv
module dram_addr_gen_chk #(
    parameter int unsigned NCOL  = 96,
    parameter int unsigned NBANK = 9,
    localparam int unsigned XW = $clog2(NCOL),
    localparam int unsigned YW = $clog2(NBANK),
    localparam int unsigned AW = $clog2(NCOL * NBANK)
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [7:0]    cmd_arg,
    input logic          data_valid,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [XW-1:0] ptr_x,
    input logic [YW-1:0] ptr_y,
    input logic          mode_vertical
);

    localparam logic [XW-1:0] XL = XW'(NCOL - 1);
    localparam logic [YW-1:0] YL = YW'(NBANK - 1);

    p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(wr_addr) < NCOL * NBANK));

    p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst)
        (32'(ptr_x) < NCOL) && (32'(ptr_y) < NBANK));

    p_write_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> wr_en);

    p_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !data_valid |=> !wr_en);

    p_horiz_step_r4: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !cmd_valid && !mode_vertical && ptr_x != XL)
        |=> (ptr_x == $past(ptr_x) + 1'b1) && $stable(ptr_y));

    p_vert_step_r5: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !cmd_valid && mode_vertical && ptr_y != YL)
        |=> (ptr_y == $past(ptr_y) + 1'b1) && $stable(ptr_x));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !cmd_valid && ptr_x == XL && ptr_y == YL)
        |=> (ptr_x == '0) && (ptr_y == '0));

    p_ignore_col_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0 && 32'(cmd_arg) >= NCOL && !data_valid)
        |=> $stable(ptr_x) && $stable(ptr_y));

    p_ignore_bank_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1 && 32'(cmd_arg) >= NBANK && !data_valid)
        |=> $stable(ptr_x) && $stable(ptr_y));

endmodule

bind dram_addr_gen dram_addr_gen_chk #(.NCOL(NCOL), .NBANK(NBANK)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_arg       (cmd_arg),
    .data_valid    (data_valid),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .ptr_x         (ptr_x),
    .ptr_y         (ptr_y),
    .mode_vertical (mode_vertical)
);

// File: tb/dram_addr_gen_test.sv
module dram_addr_gen_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       cv;
        logic [1:0] op;
        logic [7:0] arg;
        logic       dv;
        logic [7:0] db;
        logic       ew;
        logic [9:0] ea;
        logic [7:0] ed;
        logic [6:0] ex;
        logic [3:0] ey;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'h01, 1'b1, 10'd0,   8'h01, 7'd1,  4'd0}, // 0  R3 R4
        '{1'b1, 2'd0, 8'd95,  1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd95, 4'd0}, // 1  R7
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'hA5, 1'b1, 10'd95,  8'hA5, 7'd0,  4'd1}, // 2  R4 column wrap
        '{1'b1, 2'd1, 8'd8,   1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd0,  4'd8}, // 3  R7
        '{1'b1, 2'd0, 8'd95,  1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd95, 4'd8}, // 4  R7
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'h3C, 1'b1, 10'd863, 8'h3C, 7'd0,  4'd0}, // 5  R6 R3
        '{1'b1, 2'd0, 8'd120, 1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd0,  4'd0}, // 6  R8
        '{1'b1, 2'd1, 8'd9,   1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd0,  4'd0}, // 7  R8
        '{1'b1, 2'd2, 8'h01,  1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd0,  4'd0}, // 8  R7 vertical
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'h80, 1'b1, 10'd0,   8'h80, 7'd0,  4'd1}, // 9  R5
        '{1'b1, 2'd1, 8'd8,   1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd0,  4'd8}, // 10 R7
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'h11, 1'b1, 10'd768, 8'h11, 7'd1,  4'd0}, // 11 R5 bank wrap
        '{1'b1, 2'd2, 8'h0F,  1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd1,  4'd0}, // 12 R7 all flags
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'h01, 1'b1, 10'd862, 8'h80, 7'd1,  4'd1}, // 13 R9 R10 R11
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'h0E, 1'b1, 10'd766, 8'h70, 7'd1,  4'd2}, // 14 R9 R10 R11
        '{1'b1, 2'd0, 8'd5,   1'b1, 8'hF0, 1'b1, 10'd670, 8'h0F, 7'd5,  4'd3}, // 15 R12 column load
        '{1'b1, 2'd2, 8'h00,  1'b1, 8'h02, 1'b1, 10'd570, 8'h40, 7'd5,  4'd4}, // 16 R12 config change
        '{1'b0, 2'd0, 8'd0,   1'b1, 8'h02, 1'b1, 10'd389, 8'h02, 7'd6,  4'd4}, // 17 R3 R11
        '{1'b1, 2'd1, 8'd1,   1'b1, 8'h55, 1'b1, 10'd390, 8'h55, 7'd7,  4'd1}, // 18 R12 bank load
        '{1'b1, 2'd0, 8'd95,  1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd95, 4'd1}, // 19 R7
        '{1'b1, 2'd1, 8'd3,   1'b1, 8'hC3, 1'b1, 10'd191, 8'hC3, 7'd0,  4'd3}, // 20 R12 wrap plus load
        '{1'b0, 2'd0, 8'd0,   1'b0, 8'h00, 1'b0, 10'd0,   8'h00, 7'd0,  4'd3}  // 21 R2 idle
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_arg = 8'd0;
    logic       data_valid = 1'b0;
    logic [7:0] data_byte = 8'd0;
    logic       wr_en;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;
    logic [6:0] ptr_x;
    logic [3:0] ptr_y;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_addr_gen uut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_arg    (cmd_arg),
        .data_valid (data_valid),
        .data_byte  (data_byte),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ptr_x      (ptr_x),
        .ptr_y      (ptr_y)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic cv, input logic [1:0] op, input logic [7:0] arg,
                         input logic dv, input logic [7:0] db);
        cmd_valid  = cv;
        cmd_op     = op;
        cmd_arg    = arg;
        data_valid = dv;
        data_byte  = db;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 wr_en in reset", int'(wr_en), 0);
        chk("R1 ptr_x in reset", int'(ptr_x), 0);
        chk("R1 ptr_y in reset", int'(ptr_y), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cv, VEC[i].op, VEC[i].arg, VEC[i].dv, VEC[i].db);
            @(negedge clk);
            chk($sformatf("R2 vec %0d wr_en", i), int'(wr_en), int'(VEC[i].ew));
            if (VEC[i].ew) begin
                chk($sformatf("R3 vec %0d wr_addr", i), int'(wr_addr), int'(VEC[i].ea));
                chk($sformatf("R11 vec %0d wr_data", i), int'(wr_data), int'(VEC[i].ed));
            end
            chk($sformatf("R4 R5 vec %0d ptr_x", i), int'(ptr_x), int'(VEC[i].ex));
            chk($sformatf("R4 R5 vec %0d ptr_y", i), int'(ptr_y), int'(VEC[i].ey));
        end

        // R7 no-operation code leaves pointers (0,3) alone
        drive(1'b1, 2'd3, 8'd7, 1'b0, 8'h00);
        @(negedge clk);
        chk("R7 nop ptr_x", int'(ptr_x), 0);
        chk("R7 nop ptr_y", int'(ptr_y), 3);
        chk("R7 nop wr_en", int'(wr_en), 0);

        // R1 reset mid-run clears flags: set all flags and a pointer, then reset
        drive(1'b1, 2'd2, 8'h0F, 1'b0, 8'h00);
        @(negedge clk);
        drive(1'b1, 2'd0, 8'd40, 1'b0, 8'h00);
        @(negedge clk);
        drive(1'b0, 2'd0, 8'd0, 1'b1, 8'h01);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset wr_en", int'(wr_en), 0);
        chk("R1 mid-run reset ptr_x", int'(ptr_x), 0);
        chk("R1 mid-run reset ptr_y", int'(ptr_y), 0);
        rst = 1'b0;
        drive(1'b0, 2'd0, 8'd0, 1'b1, 8'h01);
        @(negedge clk);
        chk("R1 flags cleared wr_addr", int'(wr_addr), 0);
        chk("R1 flags cleared wr_data", int'(wr_data), 1);
        chk("R1 horizontal after reset ptr_x", int'(ptr_x), 1);
        drive(1'b0, 2'd0, 8'd0, 1'b0, 8'h00);
        @(negedge clk);
        chk("R2 single strobe", int'(wr_en), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule